// File: doc/BRIEF.md
# Cartridge Bus Access Adapter

This block connects a 32-bit processor bus to a cartridge that offers a 16-bit read-only memory port and an 8-bit save-memory (backup) port. It takes one bus access at a time, selects the target from the top byte of the address, and turns the access into one or two narrow requests on the chosen port. On the way back it assembles 16-bit or 8-bit results into a 32-bit read word. On the way out it moves the addressed byte of the write data down to the backup port's single byte lane.

A serial EEPROM may sit inside the ROM address space. The adapter compares each halfword access address, masked by a configurable value, against a configurable compare value. On a match the access goes to a one-bit EEPROM port instead of the ROM port. Every device port uses a fixed latency: the read data is valid in the cycle after the request, and the adapter captures it at the end of that cycle. Each completed access ends with a one-cycle ready strobe that carries the read word.

Top module: `cart_bus_adapter`

## Requirements
- R1: The top address byte selects the target. Values 0x08 to 0x0D go to the ROM port and 0x0E to 0x0F go to the backup port. Any other value raises no device request, and its read returns 0x00000000. At most one of rom_req, bk_req and eep_req is high in any cycle.
- R2: rom_addr is bus address bits 24:0 with bit 0 forced to 0. Every ROM read uses rom_be = 2'b11.
- R3: A word ROM read (bus_size 2'b10) makes exactly two ROM requests, in this order: first at (addr & ~3), then at (addr & ~3) + 2, both masked to 25 bits. The first result lands in bits 15:0 and the second in bits 31:16.
- R4: A halfword read (bus_size 2'b01) returns rom_rdata zero-extended. A byte read (bus_size 2'b00) returns rom_rdata[7:0] when addr[0] is 0 and rom_rdata[15:8] when addr[0] is 1, zero-extended in both cases.
- R5: A backup read with bk_present = 1 returns the bk_rdata byte copied into all four byte lanes. With bk_present = 0 it returns 0xFFFFFFFF and never raises bk_req.
- R6: A backup write sends one byte on bk_wdata, taken from the bus write data as follows. A word write shifts the data right by 8*addr[1:0]. A halfword write shifts it right by 8*addr[0]. A byte write uses bits 7:0 as they are. bk_addr is addr[15:0]. With bk_present = 0 a backup write raises no request.
- R7: With eep_present = 1, a ROM-region halfword access address A for which (A & eep_mask) == eep_match goes to eep_req instead of rom_req. A read places eep_rbit in bit 0 of the halfword result, so a word read gives it in bits 0 and 16. A write drives eep_wbit with bus_wdata[0].
- R8: The device request is high for exactly one cycle: the cycle after the bus request is accepted, and for a word ROM read also the cycle after the first capture. bus_ready is a one-cycle pulse. After the bus request cycle it arrives 2 cycles later for a write, 3 cycles later for a byte, halfword, backup or unmapped read, and 5 cycles later for a word ROM read.
- R9: bus_req is ignored while an access is in progress. It starts no extra device request, gives no extra ready pulse, and leaves the addresses of the current access unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, taken when the adapter is idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 or 11 word |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read word, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion strobe |
| rom_req | output | 1 | ROM port request |
| rom_we | output | 1 | ROM port write |
| rom_addr | output | 25 | ROM byte address, even |
| rom_be | output | 2 | ROM byte enables |
| rom_wdata | output | 16 | ROM write data |
| rom_rdata | input | 16 | ROM read data, one cycle after request |
| bk_present | input | 1 | Backup device fitted |
| bk_req | output | 1 | Backup port request |
| bk_we | output | 1 | Backup port write |
| bk_addr | output | 16 | Backup byte address |
| bk_wdata | output | 8 | Backup write byte |
| bk_rdata | input | 8 | Backup read byte, one cycle after request |
| eep_present | input | 1 | EEPROM fitted |
| eep_mask | input | 32 | EEPROM window address mask |
| eep_match | input | 32 | EEPROM window compare value |
| eep_req | output | 1 | EEPROM port request |
| eep_we | output | 1 | EEPROM port write |
| eep_wbit | output | 1 | EEPROM write bit |
| eep_rbit | input | 1 | EEPROM read bit, one cycle after request |

## Verification
A wrong latched sub-access index or a wrong address mux shows at the ports in the request cycle itself, as a wrong rom_addr or a request raised on the wrong port. The bench logs every request address, so such an error is caught within the same access. A wrong lane choice or a wrong capture slot corrupts bus_rdata at the ready pulse, which comes no more than five cycles after acceptance. A sequencer state that fails to return to idle shows as a missing or doubled ready pulse, or as a second request on the following accesses.

// File: rtl/cart_adapter_pkg.sv
package cart_adapter_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } size_e;

   typedef enum logic [1:0] {
      RG_NONE   = 2'b00,
      RG_ROM    = 2'b01,
      RG_BACKUP = 2'b10
   } region_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_REQ  = 2'b01,
      ST_CAP  = 2'b10
   } seq_state_e;

   function automatic logic is_word(input logic [1:0] sz);
      return sz[1];
   endfunction

endpackage

// File: rtl/cart_region_decode.sv
module cart_region_decode
   import cart_adapter_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 8,
   parameter logic [TAG_W-1:0] ROM_FIRST = 8'h08,
   parameter logic [TAG_W-1:0] ROM_LAST  = 8'h0D,
   parameter logic [TAG_W-1:0] BK_FIRST  = 8'h0E,
   parameter logic [TAG_W-1:0] BK_LAST   = 8'h0F
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              eep_present,
   input  logic [ADDR_W-1:0] eep_mask,
   input  logic [ADDR_W-1:0] eep_match,
   output region_e           region,
   output logic              eep_hit
);
   localparam int TAG_LSB = ADDR_W - TAG_W;

   logic [TAG_W-1:0] tag;
   assign tag = addr[ADDR_W-1:TAG_LSB];

   if (ROM_FIRST > ROM_LAST) begin : g_bad_rom_range
      $error("ROM region range is empty");
   end
   if (BK_FIRST > BK_LAST) begin : g_bad_bk_range
      $error("backup region range is empty");
   end

   always_comb begin
      if (tag >= ROM_FIRST && tag <= ROM_LAST)
         region = RG_ROM;
      else if (tag >= BK_FIRST && tag <= BK_LAST)
         region = RG_BACKUP;
      else
         region = RG_NONE;
   end

   assign eep_hit = eep_present && (region == RG_ROM) &&
                    ((addr & eep_mask) == eep_match);

endmodule

// File: rtl/cart_lane_pack.sv
module cart_lane_pack
   import cart_adapter_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [1:0]        size,
   input  logic [1:0]        addr_lo,
   input  logic [DATA_W-1:0] wdata,
   input  logic [HALF_W-1:0] half_in,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [HALF_W-1:0] rom_wdata,
   output logic [1:0]        rom_be_wr,
   output logic [BYTE_W-1:0] bk_byte,
   output logic [HALF_W-1:0] half_sel,
   output logic [DATA_W-1:0] byte_rep
);
   localparam int LANES      = DATA_W / BYTE_W;
   localparam int HALF_LANES = HALF_W / BYTE_W;

   if (DATA_W != 2 * HALF_W || HALF_W != 2 * BYTE_W) begin : g_bad_widths
      $error("lane packer expects word = 2 halves = 4 bytes");
   end

   // lanes of the write word, used by the backup shifter
   logic [BYTE_W-1:0] wlane [LANES];
   for (genvar g = 0; g < LANES; g++) begin : g_wlane
      assign wlane[g] = wdata[g*BYTE_W +: BYTE_W];
   end

   // replicate a backup byte over every lane
   for (genvar g = 0; g < LANES; g++) begin : g_rep
      assign byte_rep[g*BYTE_W +: BYTE_W] = byte_in;
   end

   // lanes of a halfword returned by the ROM port
   logic [BYTE_W-1:0] hlane [HALF_LANES];
   for (genvar g = 0; g < HALF_LANES; g++) begin : g_hlane
      assign hlane[g] = half_in[g*BYTE_W +: BYTE_W];
   end

   always_comb begin
      unique case (size)
         SZ_BYTE: bk_byte = wlane[0];
         SZ_HALF: bk_byte = wlane[{1'b0, addr_lo[0]}];
         default: bk_byte = wlane[addr_lo];
      endcase
   end

   always_comb begin
      if (size == SZ_BYTE)
         half_sel = {{(HALF_W-BYTE_W){1'b0}}, hlane[addr_lo[0]]};
      else
         half_sel = half_in;
   end

   always_comb begin
      if (size == SZ_BYTE) begin
         rom_wdata = {wlane[0], wlane[0]};
         rom_be_wr = addr_lo[0] ? 2'b10 : 2'b01;
      end else begin
         rom_wdata = wdata[HALF_W-1:0];
         rom_be_wr = 2'b11;
      end
   end

endmodule

// File: rtl/cart_access_seq.sv
module cart_access_seq
   import cart_adapter_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  region_e           region,
   input  logic              eep_hit,
   input  logic              bk_present,
   input  logic [DATA_W-1:0] cap_value,
   output logic              issue,
   output logic              lat_we,
   output logic [1:0]        lat_size,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [ADDR_W-1:0] sub_addr,
   output logic [DATA_W-1:0] lat_wdata,
   output logic              sub_idx,
   output logic              region_req_rom,
   output logic              region_req_eep,
   output logic              region_req_bk,
   output logic [DATA_W-1:0] rdata,
   output logic              ready
);
   localparam int HALF_W = DATA_W / 2;

   seq_state_e st;

   // address of the current halfword sub-access
   always_comb begin
      sub_addr = lat_addr;
      if (is_word(lat_size)) begin
         sub_addr[1] = sub_idx;
         sub_addr[0] = 1'b0;
      end else if (lat_size == SZ_HALF) begin
         sub_addr[0] = 1'b0;
      end
   end

   assign issue          = (st == ST_REQ);
   assign region_req_rom = issue && (region == RG_ROM) && !eep_hit;
   assign region_req_eep = issue && (region == RG_ROM) && eep_hit;
   assign region_req_bk  = issue && (region == RG_BACKUP) && bk_present;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         lat_we    <= 1'b0;
         lat_size  <= SZ_BYTE;
         lat_addr  <= '0;
         lat_wdata <= '0;
         sub_idx   <= 1'b0;
         rdata     <= '0;
         ready     <= 1'b0;
      end else begin
         ready <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (bus_req) begin
                  lat_we    <= bus_we;
                  lat_size  <= bus_size;
                  lat_addr  <= bus_addr;
                  lat_wdata <= bus_wdata;
                  sub_idx   <= 1'b0;
                  st        <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (lat_we) begin
                  ready <= 1'b1;
                  st    <= ST_IDLE;
               end else begin
                  st <= ST_CAP;
               end
            end
            ST_CAP: begin
               if (region == RG_ROM && is_word(lat_size)) begin
                  if (!sub_idx) begin
                     rdata[HALF_W-1:0] <= cap_value[HALF_W-1:0];
                     sub_idx           <= 1'b1;
                     st                <= ST_REQ;
                  end else begin
                     rdata[DATA_W-1:HALF_W] <= cap_value[HALF_W-1:0];
                     ready                  <= 1'b1;
                     st                     <= ST_IDLE;
                  end
               end else begin
                  rdata <= cap_value;
                  ready <= 1'b1;
                  st    <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cart_bus_adapter.sv
module cart_bus_adapter
   import cart_adapter_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int ROM_AW   = 25,
   parameter int ROM_DW   = 16,
   parameter int BK_AW    = 16,
   parameter int BK_DW    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   output logic              rom_req,
   output logic              rom_we,
   output logic [ROM_AW-1:0] rom_addr,
   output logic [1:0]        rom_be,
   output logic [ROM_DW-1:0] rom_wdata,
   input  logic [ROM_DW-1:0] rom_rdata,
   input  logic              bk_present,
   output logic              bk_req,
   output logic              bk_we,
   output logic [BK_AW-1:0]  bk_addr,
   output logic [BK_DW-1:0]  bk_wdata,
   input  logic [BK_DW-1:0]  bk_rdata,
   input  logic              eep_present,
   input  logic [ADDR_W-1:0] eep_mask,
   input  logic [ADDR_W-1:0] eep_match,
   output logic              eep_req,
   output logic              eep_we,
   output logic              eep_wbit,
   input  logic              eep_rbit
);
   localparam int TAG_W = 8;

   if (ROM_AW < 2 || ROM_AW > ADDR_W - TAG_W) begin : g_bad_rom_aw
      $error("ROM_AW must leave the region byte outside the ROM address");
   end
   if (BK_AW < 1 || BK_AW > ADDR_W - TAG_W) begin : g_bad_bk_aw
      $error("BK_AW out of range");
   end
   if (ROM_DW * 2 != DATA_W || BK_DW * 2 != ROM_DW) begin : g_bad_dw
      $error("data widths must be 32/16/8 shaped");
   end

   region_e           region;
   logic              eep_hit;
   logic              issue;
   logic              lat_we;
   logic [1:0]        lat_size;
   logic [ADDR_W-1:0] lat_addr;
   logic [ADDR_W-1:0] sub_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic              sub_idx;
   logic              req_rom;
   logic              req_eep;
   logic              req_bk;
   logic [DATA_W-1:0] cap_value;
   logic [ROM_DW-1:0] half_src;
   logic [ROM_DW-1:0] half_sel;
   logic [DATA_W-1:0] byte_rep;
   logic [ROM_DW-1:0] wr_half;
   logic [1:0]        wr_be;
   logic [BK_DW-1:0]  wr_byte;

   cart_region_decode #(
      .ADDR_W (ADDR_W),
      .TAG_W  (TAG_W)
   ) i_decode (
      .addr        (sub_addr),
      .eep_present (eep_present),
      .eep_mask    (eep_mask),
      .eep_match   (eep_match),
      .region      (region),
      .eep_hit     (eep_hit)
   );

   cart_access_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_req        (bus_req),
      .bus_we         (bus_we),
      .bus_size       (bus_size),
      .bus_addr       (bus_addr),
      .bus_wdata      (bus_wdata),
      .region         (region),
      .eep_hit        (eep_hit),
      .bk_present     (bk_present),
      .cap_value      (cap_value),
      .issue          (issue),
      .lat_we         (lat_we),
      .lat_size       (lat_size),
      .lat_addr       (lat_addr),
      .sub_addr       (sub_addr),
      .lat_wdata      (lat_wdata),
      .sub_idx        (sub_idx),
      .region_req_rom (req_rom),
      .region_req_eep (req_eep),
      .region_req_bk  (req_bk),
      .rdata          (bus_rdata),
      .ready          (bus_ready)
   );

   assign half_src = eep_hit ? {{(ROM_DW-1){1'b0}}, eep_rbit} : rom_rdata;

   cart_lane_pack #(
      .DATA_W (DATA_W),
      .HALF_W (ROM_DW),
      .BYTE_W (BK_DW)
   ) i_pack (
      .size      (lat_size),
      .addr_lo   (lat_addr[1:0]),
      .wdata     (lat_wdata),
      .half_in   (half_src),
      .byte_in   (bk_rdata),
      .rom_wdata (wr_half),
      .rom_be_wr (wr_be),
      .bk_byte   (wr_byte),
      .half_sel  (half_sel),
      .byte_rep  (byte_rep)
   );

   // value captured at the end of a read's data cycle
   always_comb begin
      unique case (region)
         RG_ROM:    cap_value = {{(DATA_W-ROM_DW){1'b0}}, half_sel};
         RG_BACKUP: cap_value = bk_present ? byte_rep : '1;
         default:   cap_value = '0;
      endcase
   end

   // ROM port
   assign rom_req   = req_rom;
   assign rom_we    = req_rom && lat_we;
   assign rom_addr  = {sub_addr[ROM_AW-1:1], 1'b0};
   assign rom_be    = lat_we ? wr_be : 2'b11;
   assign rom_wdata = wr_half;

   // backup port
   assign bk_req   = req_bk;
   assign bk_we    = req_bk && lat_we;
   assign bk_addr  = lat_addr[BK_AW-1:0];
   assign bk_wdata = wr_byte;

   // serial EEPROM port
   assign eep_req  = req_eep;
   assign eep_we   = req_eep && lat_we;
   assign eep_wbit = lat_wdata[0];

   logic unused_issue;
   assign unused_issue = issue;

endmodule

// File: rtl/cart_bus_adapter_chk.sv
module cart_bus_adapter_chk #(
   parameter int ROM_AW = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_ready,
   input logic              rom_req,
   input logic [ROM_AW-1:0] rom_addr,
   input logic [1:0]        rom_be,
   input logic              rom_we,
   input logic              bk_req,
   input logic              bk_present,
   input logic              eep_req
);

   assert_one_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_req, bk_req, eep_req}));

   assert_rom_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req |-> (rom_addr[0] == 1'b0));

   assert_rom_read_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_req && !rom_we) |-> (rom_be == 2'b11));

   assert_bk_absent_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bk_present |-> !bk_req);

   assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready);

   assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_req || bk_req || eep_req) |=> !(rom_req || bk_req || eep_req));

endmodule

bind cart_bus_adapter cart_bus_adapter_chk #(.ROM_AW(ROM_AW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_ready  (bus_ready),
   .rom_req    (rom_req),
   .rom_addr   (rom_addr),
   .rom_be     (rom_be),
   .rom_we     (rom_we),
   .bk_req     (bk_req),
   .bk_present (bk_present),
   .eep_req    (eep_req)
);

// File: tb/test_cart_bus_adapter.sv
module test_cart_bus_adapter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_size = 2'b00;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic        rom_req, rom_we;
   logic [24:0] rom_addr;
   logic [1:0]  rom_be;
   logic [15:0] rom_wdata;
   logic [15:0] rom_rdata = '0;
   logic        bk_present = 1'b1;
   logic        bk_req, bk_we;
   logic [15:0] bk_addr;
   logic [7:0]  bk_wdata;
   logic [7:0]  bk_rdata = '0;
   logic        eep_present = 1'b0;
   logic [31:0] eep_mask = 32'hFF00_0000;
   logic [31:0] eep_match = 32'h0D00_0000;
   logic        eep_req, eep_we, eep_wbit;
   logic        eep_rbit = 1'b0;
   logic        eep_val = 1'b1;

   int checks = 0;
   int errors = 0;
   int rom_cnt, bk_cnt, eep_cnt, rdy_cnt;
   logic [24:0] rom_log [4];
   logic [15:0] bk_last_addr;
   logic [7:0]  bk_last_wdata;
   logic        eep_last_wbit;

   always #2 clk = ~clk;

   cart_bus_adapter i_cart_bus_adapter (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .rom_req(rom_req), .rom_we(rom_we), .rom_addr(rom_addr), .rom_be(rom_be),
      .rom_wdata(rom_wdata), .rom_rdata(rom_rdata),
      .bk_present(bk_present), .bk_req(bk_req), .bk_we(bk_we), .bk_addr(bk_addr),
      .bk_wdata(bk_wdata), .bk_rdata(bk_rdata),
      .eep_present(eep_present), .eep_mask(eep_mask), .eep_match(eep_match),
      .eep_req(eep_req), .eep_we(eep_we), .eep_wbit(eep_wbit), .eep_rbit(eep_rbit)
   );

   function automatic logic [15:0] rom_model(input logic [24:0] a);
      return a[15:0] ^ 16'hA5C3;
   endfunction

   function automatic logic [7:0] bk_model(input logic [15:0] a);
      return a[7:0] ^ 8'h3C;
   endfunction

   // device models: data one cycle after the request
   always @(posedge clk) begin
      if (rom_req && !rom_we) rom_rdata <= rom_model(rom_addr);
      if (bk_req && !bk_we)   bk_rdata  <= bk_model(bk_addr);
      if (eep_req && !eep_we) eep_rbit  <= eep_val;
   end

   // port monitor, sampled mid-cycle
   always @(negedge clk) begin
      if (rom_req) begin
         if (rom_cnt < 4) rom_log[rom_cnt] = rom_addr;
         rom_cnt++;
      end
      if (bk_req) begin
         bk_cnt++;
         bk_last_addr  = bk_addr;
         bk_last_wdata = bk_wdata;
      end
      if (eep_req) begin
         eep_cnt++;
         eep_last_wbit = eep_wbit;
      end
      if (bus_ready) rdy_cnt++;
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      rom_cnt = 0; bk_cnt = 0; eep_cnt = 0; rdy_cnt = 0;
   endtask

   task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] wd, output logic [31:0] rd, output int lat);
      @(negedge clk);
      clear_mon();
      bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
      @(negedge clk);
      bus_req = 1'b0;
      lat = 1;
      while (!bus_ready && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      rd = bus_rdata;
   endtask

   task automatic t_reset();
      check(bus_ready == 1'b0, "R8 reset ready", 32'(bus_ready), 0);
      check({rom_req, bk_req, eep_req} == 3'b000, "R1 reset requests",
            32'({rom_req, bk_req, eep_req}), 0);
   endtask

   task automatic t_rom_word();
      logic [31:0] rd; int lat;
      access(1'b0, 2'b10, 32'h0812_3456, '0, rd, lat);
      check(rom_cnt == 2, "R3 word read request count", rom_cnt, 2);
      check(rom_log[0] == 25'h012_3454, "R3 first half address", 32'(rom_log[0]), 32'h0123454);
      check(rom_log[1] == 25'h012_3456, "R3 second half address", 32'(rom_log[1]), 32'h0123456);
      check(rd == {rom_model(25'h0123456), rom_model(25'h0123454)}, "R3 word assembly",
            rd, {rom_model(25'h0123456), rom_model(25'h0123454)});
      check(lat == 5, "R8 word read latency", lat, 5);
      // top bits beyond 25 are masked
      access(1'b0, 2'b10, 32'h0DFF_FFF8, '0, rd, lat);
      check(rom_log[0] == 25'h1FF_FFF8, "R2 address mask", 32'(rom_log[0]), 32'h1FFFFF8);
   endtask

   task automatic t_rom_narrow();
      logic [31:0] rd; int lat;
      access(1'b0, 2'b01, 32'h0900_0003, '0, rd, lat);
      check(rom_log[0] == 25'h100_0002, "R2 halfword clears bit 0", 32'(rom_log[0]), 32'h1000002);
      check(rd == {16'h0, rom_model(25'h1000002)}, "R4 halfword data", rd,
            {16'h0, rom_model(25'h1000002)});
      check(lat == 3 && rom_cnt == 1, "R8 halfword latency", lat, 3);
      access(1'b0, 2'b00, 32'h0800_0007, '0, rd, lat);
      check(rd == {24'h0, rom_model(25'h6)[15:8]}, "R4 odd byte", rd, {24'h0, rom_model(25'h6)[15:8]});
      access(1'b0, 2'b00, 32'h0800_0006, '0, rd, lat);
      check(rd == {24'h0, rom_model(25'h6)[7:0]}, "R4 even byte", rd, {24'h0, rom_model(25'h6)[7:0]});
   endtask

   task automatic t_backup_read();
      logic [31:0] rd; int lat;
      bk_present = 1'b1;
      access(1'b0, 2'b00, 32'h0E00_1234, '0, rd, lat);
      check(rd == {4{bk_model(16'h1234)}}, "R5 byte replicated", rd, {4{bk_model(16'h1234)}});
      check(bk_last_addr == 16'h1234 && lat == 3, "R6 backup address", 32'(bk_last_addr), 32'h1234);
      bk_present = 1'b0;
      access(1'b0, 2'b10, 32'h0F00_0010, '0, rd, lat);
      check(rd == 32'hFFFF_FFFF, "R5 absent reads all ones", rd, 32'hFFFF_FFFF);
      check(bk_cnt == 0, "R5 absent no request", bk_cnt, 0);
      bk_present = 1'b1;
   endtask

   task automatic t_backup_write();
      logic [31:0] rd; int lat;
      access(1'b1, 2'b10, 32'h0E00_0002, 32'hAABB_CCDD, rd, lat);
      check(bk_last_wdata == 8'hBB && bk_cnt == 1, "R6 word shift", 32'(bk_last_wdata), 32'hBB);
      check(lat == 2, "R8 write latency", lat, 2);
      access(1'b1, 2'b01, 32'h0F00_0001, 32'h0000_1122, rd, lat);
      check(bk_last_wdata == 8'h11, "R6 half shift", 32'(bk_last_wdata), 32'h11);
      access(1'b1, 2'b00, 32'h0E00_0003, 32'h0000_0077, rd, lat);
      check(bk_last_wdata == 8'h77, "R6 byte unshifted", 32'(bk_last_wdata), 32'h77);
      bk_present = 1'b0;
      access(1'b1, 2'b00, 32'h0E00_0003, 32'h0000_0055, rd, lat);
      check(bk_cnt == 0 && lat == 2, "R6 absent write dropped", bk_cnt, 0);
      bk_present = 1'b1;
   endtask

   task automatic t_unmapped();
      logic [31:0] rd; int lat;
      access(1'b0, 2'b10, 32'h0300_0000, '0, rd, lat);
      check(rd == 32'h0, "R1 unmapped data", rd, 0);
      check(rom_cnt + bk_cnt + eep_cnt == 0 && lat == 3, "R1 unmapped no request",
            rom_cnt + bk_cnt + eep_cnt, 0);
   endtask

   task automatic t_eeprom();
      logic [31:0] rd; int lat;
      eep_present = 1'b1; eep_val = 1'b1;
      access(1'b0, 2'b01, 32'h0D00_0010, '0, rd, lat);
      check(rd == 32'h1 && rom_cnt == 0 && eep_cnt == 1, "R7 eeprom half read", rd, 1);
      access(1'b0, 2'b10, 32'h0D00_0010, '0, rd, lat);
      check(rd == 32'h0001_0001 && eep_cnt == 2, "R7 eeprom word read", rd, 32'h00010001);
      access(1'b1, 2'b01, 32'h0D00_0000, 32'h0000_FFFE, rd, lat);
      check(eep_last_wbit == 1'b0 && eep_cnt == 1, "R7 eeprom write bit 0", 32'(eep_last_wbit), 0);
      access(1'b1, 2'b01, 32'h0D00_0000, 32'h0000_0003, rd, lat);
      check(eep_last_wbit == 1'b1 && rom_cnt == 0, "R7 eeprom write bit 1", 32'(eep_last_wbit), 1);
      access(1'b0, 2'b01, 32'h0C00_0010, '0, rd, lat);
      check(eep_cnt == 0 && rom_cnt == 1, "R7 outside window uses ROM", rom_cnt, 1);
      eep_present = 1'b0;
      access(1'b0, 2'b01, 32'h0D00_0010, '0, rd, lat);
      check(eep_cnt == 0 && rd == {16'h0, rom_model(25'h1000010)}, "R7 absent eeprom", rd,
            {16'h0, rom_model(25'h1000010)});
   endtask

   task automatic t_busy_ignore();
      @(negedge clk);
      clear_mon();
      bus_req = 1'b1; bus_we = 1'b0; bus_size = 2'b10; bus_addr = 32'h0800_0100;
      @(negedge clk);
      bus_req = 1'b0;
      @(negedge clk);
      bus_req = 1'b1; bus_addr = 32'h0900_0200;
      @(negedge clk);
      bus_req = 1'b0;
      repeat (8) @(negedge clk);
      check(rom_cnt == 2, "R9 no extra requests", rom_cnt, 2);
      check(rom_log[1] == 25'h000_0102, "R9 address held", 32'(rom_log[1]), 32'h102);
      check(rdy_cnt == 1, "R9 single ready", rdy_cnt, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_rom_word();
      t_rom_narrow();
      t_backup_read();
      t_backup_write();
      t_unmapped();
      t_eeprom();
      t_busy_ignore();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule